// File: doc/BRIEF.md
# Quad-Word Burst SRAM Core

This block is an on-chip memory whose command port behaves like a double-data-rate SRAM that moves four words per transaction. It is modelled at single rate. Each clock cycle carries a pair of words: an early word and a late word, standing for the two halves of a clock period. A command is defined by sampling an active-low load strobe, a read/write select and a word address on a rising clock edge. The block then runs a four-word burst over the next two cycles, and no other command can enter during that time.

The two lowest address bits choose the word within the aligned four-word group where the burst starts. The burst then walks linearly through the group and wraps around. The upper address bits do not change during the burst. Writes take one active-low byte mask per word, so each half-cycle word has its own mask. Reads return the same early/late split, marked by a valid flag. A new command may be placed in the last cycle of a burst, which lets bursts follow one another with no idle cycle.

Top module: `qb_burst_sram`

## Requirements
- R1: While reset is low and in the cycle after it, rvalid is 0 and both read data outputs are zero.
- R2: A load (ld_n low at a rising edge, rd_sel high) with no burst in progress starts a read. rvalid is 1 in exactly the two cycles after the load cycle.
- R3: A load with rd_sel low starts a write. The first word pair is taken from the cycle after the load cycle and the second pair from the cycle after that.
- R4: If s is addr[1:0] at the load, the first pair is words s and s+1 and the second pair is words s+2 and s+3. All four word indices are taken modulo 4, and the upper address bits stay the same.
- R5: A byte is written only when its mask bit is low. Mask bit i (i < BYTES) covers byte i of the early word, and bit BYTES+i covers byte i of the late word.
- R6: A byte whose mask bit is high keeps its previous contents.
- R7: A load sampled in the first cycle of a burst is ignored, together with its address and direction.
- R8: A load sampled in the second cycle of a burst is accepted, so consecutive bursts move data with no gap.
- R9: rd_e and rd_l are zero in every cycle where rvalid is 0.
- R10: While ld_n is high and no burst runs, changes on the address, select, data and mask inputs alter neither the memory nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Command load strobe, active low |
| rd_sel | input | 1 | 1 = read, 0 = write, sampled with the load |
| addr | input | ADDR_W | Word address; bits [1:0] give the start word |
| wd_e | input | BYTES*BYTE_W | Early write word of the current pair |
| wd_l | input | BYTES*BYTE_W | Late write word of the current pair |
| bwe_n | input | 2*BYTES | Byte write masks, active low; low half for the early word |
| rvalid | output | 1 | Read pair valid |
| rd_e | output | BYTES*BYTE_W | Early read word |
| rd_l | output | BYTES*BYTE_W | Late read word |

## Verification
The bench builds the block with ADDR_W = 5 and BYTES = 2. This gives eight burst groups, so random traffic keeps returning to locations written earlier, and a full shadow copy of the array can be compared on every read. With two bytes per word, the mask vector has four bits, so random stimulus reaches every mask combination for both halves of a pair. Directed sequences cover a load in each burst cycle, every start offset, back-to-back reads and writes, and idle cycles with active-looking inputs.

// File: rtl/qb_pkg.sv
package qb_pkg;
   typedef enum logic [1:0] {
      QB_IDLE   = 2'd0,
      QB_FIRST  = 2'd1,
      QB_SECOND = 2'd2
   } qb_state_e;
endpackage

// File: rtl/qb_seq.sv
module qb_seq
   import qb_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] addr,
   output qb_state_e         st,
   output logic [ADDR_W-1:0] base_q,
   output logic              rd_q
);
   logic accept;

   // a load is taken when idle or in the closing cycle of a burst
   assign accept = !ld_n && (st != QB_FIRST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= QB_IDLE;
         base_q <= '0;
         rd_q   <= 1'b0;
      end else if (accept) begin
         st     <= QB_FIRST;
         base_q <= addr;
         rd_q   <= rd_sel;
      end else begin
         case (st)
            QB_FIRST:  st <= QB_SECOND;
            QB_SECOND: st <= QB_IDLE;
            default:   st <= QB_IDLE;
         endcase
      end
   end

   // R1
   rst_idle_chk: assert property (@(posedge clk) !rst_n |=> st == QB_IDLE);

   // R2
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == QB_FIRST |=> st == QB_SECOND);

   // R7
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == QB_FIRST |=> ($stable(base_q) && $stable(rd_q)));

   // R8
   chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == QB_SECOND && !ld_n) |=> st == QB_FIRST);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == QB_IDLE && ld_n) |=> st == QB_IDLE);
endmodule

// File: rtl/qb_agen.sv
module qb_agen #(
   parameter int ADDR_W = 8
) (
   input  logic                   second,
   input  logic [ADDR_W-1:0]      base,
   output logic [1:0][ADDR_W-1:0] wa
);
   localparam int HI_W = ADDR_W - 2;

   // lane 0 = early word, lane 1 = late word; index wraps in the group
   for (genvar i = 0; i < 2; i++) begin : g_lane
      logic [1:0] off;
      logic [1:0] idx;
      assign off = {second, 1'(i)};
      assign idx = base[1:0] + off;
      assign wa[i] = {base[ADDR_W-1 -: HI_W], idx};
   end
endmodule

// File: rtl/qb_array.sv
module qb_array #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic [1:0][ADDR_W-1:0]        wa,
   input  logic [1:0][BYTES*BYTE_W-1:0]  wd,
   input  logic [2*BYTES-1:0]            bm_n,
   output logic [1:0][BYTES*BYTE_W-1:0]  rd
);
   localparam int WORD_W = BYTES * BYTE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < BYTES; b++) begin
               if (!bm_n[p*BYTES + b])
                  mem[wa[p]][b*BYTE_W +: BYTE_W] <= wd[p][b*BYTE_W +: BYTE_W];
            end
         end
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rport
      assign rd[p] = mem[wa[p]];
   end

   // R4
   lane_pair_chk: assert property (@(posedge clk)
      we |-> (wa[0][ADDR_W-1:2] == wa[1][ADDR_W-1:2] && wa[0][1:0] != wa[1][1:0]));
endmodule

// File: rtl/qb_burst_sram.sv
module qb_burst_sram
   import qb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_n,
   input  logic                      rd_sel,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BYTES*BYTE_W-1:0]   wd_e,
   input  logic [BYTES*BYTE_W-1:0]   wd_l,
   input  logic [2*BYTES-1:0]        bwe_n,
   output logic                      rvalid,
   output logic [BYTES*BYTE_W-1:0]   rd_e,
   output logic [BYTES*BYTE_W-1:0]   rd_l
);
   localparam int WORD_W = BYTES * BYTE_W;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("qb_burst_sram: ADDR_W must be at least 3");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("qb_burst_sram: BYTES must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_bw
      $error("qb_burst_sram: BYTE_W must be at least 1");
   end

   qb_state_e                st;
   logic [ADDR_W-1:0]        base_q;
   logic                     rd_q;
   logic                     busy;
   logic                     we;
   logic [1:0][ADDR_W-1:0]   wa;
   logic [1:0][WORD_W-1:0]   wd;
   logic [1:0][WORD_W-1:0]   arr_rd;

   qb_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_n   (ld_n),
      .rd_sel (rd_sel),
      .addr   (addr),
      .st     (st),
      .base_q (base_q),
      .rd_q   (rd_q)
   );

   qb_agen #(.ADDR_W(ADDR_W)) u_agen (
      .second (st == QB_SECOND),
      .base   (base_q),
      .wa     (wa)
   );

   assign busy = (st != QB_IDLE);
   assign we   = busy && !rd_q;
   assign wd   = {wd_l, wd_e};

   qb_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
      .clk  (clk),
      .we   (we),
      .wa   (wa),
      .wd   (wd),
      .bm_n (bwe_n),
      .rd   (arr_rd)
   );

   assign rvalid = busy && rd_q;
   assign rd_e   = rvalid ? arr_rd[0] : '0;
   assign rd_l   = rvalid ? arr_rd[1] : '0;

   // R2
   rv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid);
endmodule

// File: tb/sim_qb_burst_sram.sv
`timescale 1ns/1ps
module sim_qb_burst_sram;
   localparam int AW = 5;
   localparam int NB = 2;
   localparam int BW = 8;
   localparam int WW = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b1;
   logic          rd_sel = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [WW-1:0] wd_e = '0;
   logic [WW-1:0] wd_l = '0;
   logic [2*NB-1:0] bwe_n = '1;
   logic          rvalid;
   logic [WW-1:0] rd_e;
   logic [WW-1:0] rd_l;

   int nchk = 0;
   int nfail = 0;
   string cur_tag = "R4";

   logic [WW-1:0] sh [DEPTH];
   int            eph = 0;
   logic [AW-1:0] ebase = '0;
   logic          erd = 1'b0;

   always #2.5 clk = ~clk;

   qb_burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_sel(rd_sel), .addr(addr),
      .wd_e(wd_e), .wd_l(wd_l), .bwe_n(bwe_n),
      .rvalid(rvalid), .rd_e(rd_e), .rd_l(rd_l)
   );

   function automatic logic [AW-1:0] wa(input logic [AW-1:0] b, input int k);
      logic [1:0] idx;
      idx = b[1:0] + 2'(k);
      return {b[AW-1:2], idx};
   endfunction

   task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_outputs();
      int k;
      if (eph != 0 && erd) begin
         k = (eph == 2) ? 2 : 0;
         chk("R2", WW'(rvalid), WW'(1));
         chk(cur_tag, rd_e, sh[wa(ebase, k)]);
         chk(cur_tag, rd_l, sh[wa(ebase, k + 1)]);
      end else begin
         chk("R2", WW'(rvalid), WW'(0));
         chk("R9", rd_e, '0);
         chk("R9", rd_l, '0);
      end
   endtask

   task automatic model_step(input logic l, input logic r, input logic [AW-1:0] a,
                             input logic [WW-1:0] e, input logic [WW-1:0] lt,
                             input logic [2*NB-1:0] m);
      logic [AW-1:0] w0, w1;
      if (eph != 0 && !erd) begin
         w0 = wa(ebase, (eph == 2) ? 2 : 0);
         w1 = wa(ebase, (eph == 2) ? 3 : 1);
         for (int b = 0; b < NB; b++) begin
            if (!m[b])      sh[w0][b*BW +: BW] = e[b*BW +: BW];
            if (!m[NB + b]) sh[w1][b*BW +: BW] = lt[b*BW +: BW];
         end
      end
      if (!l && eph != 1) begin
         eph = 1; ebase = a; erd = r;
      end else if (eph == 1) begin
         eph = 2;
      end else begin
         eph = 0;
      end
   endtask

   task automatic cyc(input logic l, input logic r, input logic [AW-1:0] a,
                      input logic [WW-1:0] e, input logic [WW-1:0] lt,
                      input logic [2*NB-1:0] m);
      @(negedge clk);
      check_outputs();
      ld_n = l; rd_sel = r; addr = a; wd_e = e; wd_l = lt; bwe_n = m;
      model_step(l, r, a, e, lt, m);
   endtask

   task automatic idle();
      cyc(1'b1, 1'b0, '0, '0, '0, '1);
   endtask

   task automatic rd_burst(input logic [AW-1:0] a);
      cyc(1'b0, 1'b1, a, '0, '0, '1);
      idle();
      idle();
   endtask

   task automatic wr_burst(input logic [AW-1:0] a, input logic [2*NB-1:0] m0,
                           input logic [2*NB-1:0] m1);
      cyc(1'b0, 1'b0, a, '0, '0, '1);
      cyc(1'b1, 1'b0, '0, WW'($urandom), WW'($urandom), m0);
      cyc(1'b1, 1'b0, '0, WW'($urandom), WW'($urandom), m1);
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet under reset
      chk("R1", WW'(rvalid), WW'(0));
      chk("R1", rd_e, '0);
      chk("R1", rd_l, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", WW'(rvalid), WW'(0));
      chk("R1", rd_l, '0);

      // R3: fill every group, start offsets varied
      cur_tag = "R3";
      for (int g = 0; g < DEPTH / 4; g++) wr_burst(AW'(g * 4 + (g % 4)), '0, '0);
      for (int g = 0; g < DEPTH / 4; g++) rd_burst(AW'(g * 4));

      // R4: every start offset in every group
      cur_tag = "R4";
      for (int g = 0; g < DEPTH / 4; g++)
         for (int s = 1; s < 4; s++) rd_burst(AW'(g * 4 + s));

      // R5 / R6: split masks on each half of the pair
      cur_tag = "R5";
      wr_burst(AW'(25), 4'b1010, 4'b0101);
      cur_tag = "R6";
      rd_burst(AW'(24));
      rd_burst(AW'(27));

      // R7: load in the first burst cycle is dropped
      cur_tag = "R7";
      cyc(1'b0, 1'b1, AW'(1), '0, '0, '1);
      cyc(1'b0, 1'b0, AW'(8), WW'(16'hdead), WW'(16'hbeef), '0);
      cyc(1'b1, 1'b0, '0, WW'(16'h1111), WW'(16'h2222), '0);
      rd_burst(AW'(8));

      // R8: chained reads and writes
      cur_tag = "R8";
      cyc(1'b0, 1'b1, AW'(4), '0, '0, '1);
      idle();
      cyc(1'b0, 1'b1, AW'(14), '0, '0, '1);
      idle();
      cyc(1'b0, 1'b0, AW'(16), '0, '0, '1);
      cyc(1'b1, 1'b0, '0, WW'($urandom), WW'($urandom), '0);
      cyc(1'b0, 1'b0, AW'(23), WW'($urandom), WW'($urandom), '0);
      cyc(1'b1, 1'b0, '0, WW'($urandom), WW'($urandom), 4'b0011);
      cyc(1'b0, 1'b1, AW'(18), WW'($urandom), WW'($urandom), '0);
      idle();
      rd_burst(AW'(21));

      // R10: deselected cycles with busy-looking inputs
      cur_tag = "R10";
      for (int i = 0; i < 6; i++)
         cyc(1'b1, 1'(i % 2), AW'($urandom), WW'($urandom), WW'($urandom), '0);
      for (int g = 0; g < DEPTH / 4; g++) rd_burst(AW'(g * 4 + 2));

      // random traffic
      cur_tag = "R4";
      for (int i = 0; i < 4000; i++) begin
         logic [2*NB-1:0] m;
         m = ($urandom % 4 == 0) ? '0 : (2*NB)'($urandom);
         cyc(($urandom % 5) < 2, 1'($urandom), AW'($urandom),
             WW'($urandom), WW'($urandom), m);
      end
      idle(); idle(); idle();

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      nfail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule